// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a slave serial control port. It lets an external host read and write a small bank of configuration registers, and it presents the whole bank to the rest of the chip as one flat parallel bus. The host selects the port with an active-low select, moves bits with a serial clock and sends data on a data pin. The port can return read data on that same pin (3-wire operation) or on a separate output pin (4-wire operation). One bit in register 0 chooses between the two. A synchronising input lets the host abandon a transfer at any point. It leaves every register as it was.

Each transfer opens with an 8-bit instruction: a direction bit, two unused bits and a 5-bit register address. One or more data bytes follow, and the address advances by one after each byte. All port pins are sampled on the system clock through a short synchroniser, and serial clock edges are found in that domain. The tristate pins appear as a data output plus an output-enable.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset every register in the bank reads 0x00, so the data pin is in bidirectional mode, and both `sdio_oe` and `sdo_oe` are low.
- R2: While `cs_n` is high, serial clock and data activity changes no register and enables no output.
- R3: The instruction byte is sent MSB first. Bit 7 = 1 requests a read and bit 7 = 0 requests a write. Bits 4:0 give the start address, and bits 6:5 are ignored.
- R4: Write data is sampled on rising `sclk` edges, MSB first. A byte is committed only after its 8th bit. Writes to addresses at or above NUM_REGS (8 by default) are dropped, and reads from those addresses return 0x00.
- R5: In bidirectional mode, read data is driven on `sdio_out` with `sdio_oe` high. The output changes only after falling `sclk` edges, MSB first, starting at the falling edge that ends the instruction byte.
- R6: When bit 7 of register 0x00 is 1 (input-only mode), read data leaves on `sdo_out` with `sdo_oe` high, and `sdio_oe` stays low.
- R7: `sdo_oe` is high only during the read phase of a transfer in input-only mode. The two enables are never high together.
- R8: A high `sync_abort` ends the transfer in progress and drops both enables without changing any register. The next 8 bits, with `cs_n` still low, are taken as a new instruction.
- R9: A data byte that `cs_n` rising or `sync_abort` cuts short is discarded.
- R10: In a transfer with several data bytes, the address increments after each byte, for writes and for reads alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low port select |
| sclk | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Serial data into the port |
| sync_abort | input | 1 | Active-high transfer abort |
| sdio_out | output | 1 | Read data for the bidirectional data pin |
| sdio_oe | output | 1 | Drive enable for the bidirectional data pin |
| sdo_out | output | 1 | Read data for the separate output pin |
| sdo_oe | output | 1 | Drive enable for the separate output pin |
| reg_q | output | NUM_REGS*DATA_W | Register bank; register n sits at bits n*8 +: 8 |

## Verification
A vector table writes distinct bytes to every implemented address and to one address out of range, then reads each one back. This tells correct address decoding and MSB-first bit order apart from shifted or mirrored data, and it shows that out-of-range writes are dropped. Bursts of several bytes in each direction separate auto-increment from single-byte access. An instruction with bits 6:5 set shows that those bits are ignored. Transfers cut off by select or by sync, and clocking while deselected, show whether partial bytes and stray edges leak into the bank. The same read is repeated in both pin modes, and enable activity is recorded during writes and reads, to check which pin is driven in each phase.

// File: rtl/scp_pkg.sv
package scp_pkg;
   typedef enum logic {PH_INSTR = 1'b0, PH_DATA = 1'b1} phase_e;
   localparam int INSTR_RD_BIT = 7;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   input  logic [W-1:0] rst_val,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= rst_val;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/scp_regbank.sv
module scp_regbank #(
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [ADDR_W-1:0]          rd_addr,
   output logic [DATA_W-1:0]          rd_data,
   output logic [NUM_REGS*DATA_W-1:0] bank_q
);
   genvar gi;
   generate
      for (gi = 0; gi < NUM_REGS; gi++) begin : g_reg
         logic [DATA_W-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else if (wr_en && (int'(wr_addr) == gi)) r <= wr_data;
         end
         assign bank_q[gi*DATA_W +: DATA_W] = r;
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      if (int'(rd_addr) < NUM_REGS) rd_data = bank_q[int'(rd_addr)*DATA_W +: DATA_W];
   end
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 8,
   parameter int NUM_REGS    = 8,
   parameter int SYNC_STAGES = 2,
   parameter int MODE_REG    = 0,
   parameter int MODE_BIT    = 7
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cs_n,
   input  logic                       sclk,
   input  logic                       sdio_in,
   input  logic                       sync_abort,
   output logic                       sdio_out,
   output logic                       sdio_oe,
   output logic                       sdo_out,
   output logic                       sdo_oe,
   output logic [NUM_REGS*DATA_W-1:0] reg_q
);
   import scp_pkg::*;

   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   if (DATA_W < ADDR_W + 1 || DATA_W <= INSTR_RD_BIT) begin : g_bad_width
      $error("serial_cfg_port: DATA_W too small for instruction format");
   end
   if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_depth
      $error("serial_cfg_port: NUM_REGS out of address range");
   end
   if (MODE_REG >= NUM_REGS || MODE_BIT >= DATA_W) begin : g_bad_mode
      $error("serial_cfg_port: mode bit outside register bank");
   end

   // synchronised pins: {cs, sclk, data, sync}
   logic [3:0] pins_s;
   scp_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({cs_n, sclk, sdio_in, sync_abort}),
      .rst_val(4'b1000),
      .q(pins_s)
   );
   logic cs_s, sclk_s, din_s, sync_s;
   assign {cs_s, sclk_s, din_s, sync_s} = pins_s;

   logic              sclk_d;
   logic              rise, fall, abort;
   phase_e            phase;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] sh_in, out_sh, nxt, rdata;
   logic              is_rd, rd_drv, wr_en, mode_in_only;
   logic [ADDR_W-1:0] addr;

   assign abort = cs_s | sync_s;
   assign rise  = !cs_s && sclk_s && !sclk_d;
   assign fall  = !cs_s && !sclk_s && sclk_d;
   assign nxt   = {sh_in[DATA_W-2:0], din_s};
   assign wr_en = rise && !abort && (phase == PH_DATA) && !is_rd && (cnt == LAST);

   scp_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(addr), .wr_data(nxt),
      .rd_addr(addr), .rd_data(rdata),
      .bank_q(reg_q)
   );

   assign mode_in_only = reg_q[MODE_REG*DATA_W + MODE_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         phase  <= PH_INSTR;
         cnt    <= '0;
         sh_in  <= '0;
         out_sh <= '0;
         is_rd  <= 1'b0;
         rd_drv <= 1'b0;
         addr   <= '0;
      end else begin
         sclk_d <= sclk_s;
         if (abort) begin
            phase  <= PH_INSTR;
            cnt    <= '0;
            rd_drv <= 1'b0;
         end else begin
            if (rise) begin
               sh_in <= nxt;
               cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
               if (cnt == LAST) begin
                  if (phase == PH_INSTR) begin
                     is_rd <= nxt[INSTR_RD_BIT];
                     addr  <= nxt[ADDR_W-1:0];
                     phase <= PH_DATA;
                  end else begin
                     addr <= addr + 1'b1;
                  end
               end
            end
            if (fall && phase == PH_DATA && is_rd) begin
               rd_drv <= 1'b1;
               out_sh <= (cnt == '0) ? rdata : {out_sh[DATA_W-2:0], 1'b0};
            end
         end
      end
   end

   assign sdio_out = out_sh[DATA_W-1];
   assign sdo_out  = out_sh[DATA_W-1];
   assign sdio_oe  = rd_drv && !mode_in_only;
   assign sdo_oe   = rd_drv && mode_in_only;
endmodule

// File: rtl/scp_checker.sv
module scp_checker #(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 8,
   parameter int MODE_REG = 0,
   parameter int MODE_BIT = 7
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       cs_s,
   input logic                       sync_s,
   input logic                       fall,
   input logic                       wr_en,
   input logic                       sdio_out,
   input logic                       sdio_oe,
   input logic                       sdo_oe,
   input logic [NUM_REGS*DATA_W-1:0] reg_q
);
   logic mode;
   assign mode = reg_q[MODE_REG*DATA_W + MODE_BIT];

   // R2: deselected port holds bank and releases pins
   a_r2_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> (!sdio_oe && !sdo_oe && $stable(reg_q)));
   // R4: bank changes only on a completed byte
   a_r4_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(reg_q));
   // R5: read data moves only after falling serial clock
   a_r5_shift_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !fall |=> $stable(sdio_out));
   // R6: bidirectional pin silent in input-only mode
   a_r6_pin_select: assert property (@(posedge clk) disable iff (!rst_n)
      sdio_oe |-> !mode);
   // R7: separate pin only in input-only mode, never both enables
   a_r7_sdo_mode: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> mode);
   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(sdio_oe && sdo_oe));
   // R8: abort releases pins and keeps registers
   a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
      sync_s |=> (!sdio_oe && !sdo_oe && $stable(reg_q)));
endmodule

bind serial_cfg_port scp_checker #(
   .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .MODE_REG(MODE_REG), .MODE_BIT(MODE_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sync_s(sync_s), .fall(fall),
   .wr_en(wr_en), .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_oe(sdo_oe),
   .reg_q(reg_q)
);

// File: tb/sim_serial_cfg_port.sv
`timescale 1ns/1ps
module sim_serial_cfg_port;
   localparam int NR = 8;
   localparam int H  = 6;

   logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdio_in = 1'b0, sync_abort = 1'b0;
   logic sdio_out, sdio_oe, sdo_out, sdo_oe;
   logic [NR*8-1:0] reg_q;

   serial_cfg_port u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_in(sdio_in),
      .sync_abort(sync_abort), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
      .sdo_out(sdo_out), .sdo_oe(sdo_oe), .reg_q(reg_q)
   );

   always #4 clk = ~clk;

   int n_chk = 0, n_fail = 0, unstable = 0;
   bit done = 0, sdo_mode = 0, seen_io = 0, seen_so = 0;
   logic [7:0] model [32];

   // {addr[4:0], data[7:0]}
   localparam logic [12:0] VEC [9] = '{
      {5'd1, 8'hA5}, {5'd2, 8'h3C}, {5'd3, 8'hFF}, {5'd4, 8'h01}, {5'd5, 8'h81},
      {5'd6, 8'h7E}, {5'd7, 8'h5A}, {5'd0, 8'h15}, {5'd9, 8'hCC}};

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] bank(input int a);
      return reg_q[a*8 +: 8];
   endfunction

   task automatic xbits(input logic [7:0] w, input int n, output logic [7:0] r);
      r = '0;
      for (int i = 7; i >= 8 - n; i--) begin
         logic b0, b1;
         @(negedge clk) sdio_in = w[i];
         repeat (H) @(negedge clk);
         b0 = sdo_mode ? sdo_out : sdio_out;
         if (sdio_oe) seen_io = 1;
         if (sdo_oe) seen_so = 1;
         r[i] = b0;
         sclk = 1'b1;
         repeat (H) @(negedge clk);
         b1 = sdo_mode ? sdo_out : sdio_out;
         if (b1 !== b0) unstable++;
         sclk = 1'b0;
      end
   endtask

   task automatic xbyte(input logic [7:0] w, output logic [7:0] r);
      xbits(w, 8, r);
   endtask

   task automatic sel();
      @(negedge clk) cs_n = 1'b0;
      repeat (H) @(negedge clk);
   endtask

   task automatic desel();
      repeat (H) @(negedge clk);
      cs_n = 1'b1;
      repeat (H) @(negedge clk);
   endtask

   task automatic pulse_sync();
      @(negedge clk) sync_abort = 1'b1;
      repeat (4) @(negedge clk);
      sync_abort = 1'b0;
      repeat (H) @(negedge clk);
   endtask

   task automatic wr1(input logic [4:0] a, input logic [7:0] d);
      logic [7:0] dummy;
      sel();
      xbyte({3'b000, a}, dummy);
      xbyte(d, dummy);
      desel();
      if (a < NR) model[a] = d;
   endtask

   task automatic rd1(input logic [4:0] a, output logic [7:0] r);
      logic [7:0] dummy;
      sel();
      xbyte({3'b100, a}, dummy);
      xbyte(8'h00, r);
      desel();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] r, d;
      logic [NR*8-1:0] snap;
      for (int i = 0; i < 32; i++) model[i] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1 reset state
      chk(reg_q == '0, "R1 bank", reg_q, 0);
      chk(!sdio_oe && !sdo_oe, "R1 enables", {sdio_oe, sdo_oe}, 0);

      // Vector table: R4 write / R5 read / R3 address
      for (int v = 0; v < 9; v++) begin
         logic [4:0] a;
         a = VEC[v][12:8];
         seen_io = 0; seen_so = 0;
         wr1(a, VEC[v][7:0]);
         chk(seen_io == 0 && seen_so == 0, "R7 no drive on write", {seen_io, seen_so}, 0);
         if (a < NR) chk(bank(a) == model[a], "R4 parallel", bank(a), model[a]);
         seen_io = 0; seen_so = 0;
         rd1(a, r);
         chk(r == model[a], "R4 R5 readback", r, model[a]);
         chk(seen_io == 1 && seen_so == 0, "R5 R7 sdio driven", {seen_io, seen_so}, 2'b10);
         chk(!sdio_oe && !sdo_oe, "R5 release", {sdio_oe, sdo_oe}, 0);
      end
      chk(unstable == 0, "R5 change only after fall", unstable, 0);

      // R10 burst write then burst read
      sel();
      xbyte(8'h02, r); xbyte(8'h11, r); xbyte(8'h22, r); xbyte(8'h33, r);
      desel();
      model[2] = 8'h11; model[3] = 8'h22; model[4] = 8'h33;
      chk({bank(2), bank(3), bank(4)} == 24'h112233, "R10 burst write", {bank(2), bank(3), bank(4)}, 24'h112233);
      sel();
      xbyte(8'h82, r);
      xbyte(8'h00, r); chk(r == 8'h11, "R10 burst read 0", r, 8'h11);
      xbyte(8'h00, r); chk(r == 8'h22, "R10 burst read 1", r, 8'h22);
      xbyte(8'h00, r); chk(r == 8'h33, "R10 burst read 2", r, 8'h33);
      desel();

      // R3 bits 6:5 ignored
      sel(); xbyte(8'hE3, r); xbyte(8'h00, r); desel();
      chk(r == model[3], "R3 read ignores 6:5", r, model[3]);
      sel(); xbyte(8'h65, r); xbyte(8'h99, r); desel();
      model[5] = 8'h99;
      chk(bank(5) == 8'h99, "R3 write ignores 6:5", bank(5), 8'h99);

      // R2 deselected activity ignored
      snap = reg_q;
      seen_io = 0; seen_so = 0;
      xbyte(8'h01, r); xbyte(8'hFF, r);
      chk(reg_q == snap, "R2 bank unchanged", reg_q, snap);
      chk(seen_io == 0 && seen_so == 0, "R2 no drive", {seen_io, seen_so}, 0);

      // R9 partial byte cut by cs_n
      sel(); xbyte(8'h01, r); xbits(8'h00, 5, r); desel();
      chk(bank(1) == model[1], "R9 partial on cs", bank(1), model[1]);

      // R8 sync during read, then new instruction in same select
      sel(); xbyte(8'h83, r); xbits(8'h00, 3, r);
      pulse_sync();
      chk(!sdio_oe && !sdo_oe, "R8 enables dropped", {sdio_oe, sdo_oe}, 0);
      xbyte(8'h04, r); xbyte(8'h5A, r);
      desel();
      model[4] = 8'h5A;
      chk(bank(4) == 8'h5A, "R8 new instruction after sync", bank(4), 8'h5A);
      chk(bank(3) == model[3], "R8 registers kept", bank(3), model[3]);

      // R9 partial byte cut by sync
      sel(); xbyte(8'h06, r); xbits(8'hFF, 4, r);
      pulse_sync();
      xbyte(8'h86, r); xbyte(8'h00, r);
      desel();
      chk(r == model[6], "R9 partial on sync", r, model[6]);

      // R6 / R7 input-only mode
      wr1(5'd0, 8'h80);
      chk(bank(0) == 8'h80, "R6 mode bit set", bank(0), 8'h80);
      sdo_mode = 1;
      seen_io = 0; seen_so = 0;
      rd1(5'd5, r);
      chk(r == 8'h99, "R6 read on sdo", r, 8'h99);
      chk(seen_io == 0 && seen_so == 1, "R6 R7 pin choice", {seen_io, seen_so}, 2'b01);
      chk(!sdo_oe, "R7 sdo released", sdo_oe, 0);
      seen_io = 0; seen_so = 0;
      wr1(5'd7, 8'h42);
      chk(seen_so == 0 && seen_io == 0, "R7 sdo quiet on write", {seen_io, seen_so}, 0);
      chk(bank(7) == 8'h42, "R4 write in input-only mode", bank(7), 8'h42);
      wr1(5'd0, 8'h00);
      sdo_mode = 0;
      seen_io = 0; seen_so = 0;
      rd1(5'd7, r);
      chk(r == 8'h42, "R5 back to bidirectional", r, 8'h42);
      chk(seen_io == 1 && seen_so == 0, "R7 sdo idle in default", {seen_io, seen_so}, 2'b10);
      chk(unstable == 0, "R5 stable across rise", unstable, 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule